// File: doc/BRIEF.md
# PHY Management Register File

This block holds the management register set of a Fast Ethernet PHY as seen from the MAC side. A host reaches it indirectly. It first loads a target register that names a PHY address and a register index. It then either pulses a read strobe, which returns the selected register one cycle later, or a write strobe, which updates the selected register. Only accesses whose PHY address equals the configured address reach the registers.

The block keeps a control word, a status word, a local advertisement word and a link-partner ability word. It returns two fixed identifier words, and it tracks a link-up input. A hardware reset and a self-clearing soft reset both reload the defaults. The soft reset is a write to the control word with its top bit set. Both resets then apply the link state present at that moment.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset the control word reads 0x3100 (bit 13 speed 100, bit 12 auto-negotiation enable, bit 8 full duplex), the advertisement word reads 0x01E1, the target register reads 0 and rd_valid is low.
- R2: The status word is 0x7848 with the link down: 100TX full/half, 10T full/half, preamble suppression (bit 6) and auto-negotiation ability (bit 3). With the link up it is 0x786C, adding link status (bit 2) and auto-negotiation complete (bit 5).
- R3: When the link rises, partner ability gains 0x0141 on top of its current value. When the link falls, partner ability becomes exactly 0x0080. After a reset it is 0x0080 with the link down and 0x01C1 with the link up.
- R4: A change on link_up takes effect at the clock edge that samples it. A read issued at that same edge returns the old value.
- R5: The target register holds the PHY address in bits [15:8] and the register index in bits [7:0]. A read or write uses the target value held before its edge, even if the target is being rewritten at that edge.
- R6: A read whose target PHY address differs from the configured address returns 0xFFFF.
- R7: Index 0 reads control, 1 status, 2 the first ID word, 3 the second ID word, 4 advertisement and 5 partner ability. Every other index (2..255 excluding those named) reads 0.
- R8: A write to index 0 with bit 15 clear stores the written value in the control word. A write to index 4 stores the written value in the advertisement word.
- R9: A write to index 0 with bit 15 set reloads the control, status, advertisement and partner words with their reset values and the current link state. The written value is not stored.
- R10: Writes to any index other than 0 and 4 change nothing. Writes whose target PHY address does not match change nothing.
- R11: rd_valid pulses and rd_data updates exactly one cycle after rd_en. rd_data holds its value when no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up | input | 1 | Current link state from the line side |
| tgt_we | input | 1 | Load the target register |
| tgt_wdata | input | 16 | Target value: PHY address [15:8], index [7:0] |
| tgt_q | output | 16 | Current target register |
| rd_en | input | 1 | Read the targeted register |
| rd_data | output | 16 | Registered read result |
| rd_valid | output | 1 | High for the cycle after rd_en |
| wr_en | input | 1 | Write wr_data to the targeted register |
| wr_data | input | 16 | Write value |

## Verification
The bench builds the block with PHY address 5 and identifier words 0x1357 and 0x9BDF. With 8-bit address and index fields, this brings the whole space into reach. Every one of the 256 indices is read and written at the matching address, and every one of the 256 addresses is tried for both reads and writes. The link is toggled with a read on the same edge. Soft resets are issued with the link in each state, so the expected partner value differs between the two cases.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int REG_W = 16;

  localparam logic [7:0] IDX_CTRL    = 8'd0;
  localparam logic [7:0] IDX_STAT    = 8'd1;
  localparam logic [7:0] IDX_ID_HI   = 8'd2;
  localparam logic [7:0] IDX_ID_LO   = 8'd3;
  localparam logic [7:0] IDX_ADV     = 8'd4;
  localparam logic [7:0] IDX_PARTNER = 8'd5;

  localparam int CTRL_SOFT_RST_BIT = 15;

  localparam logic [REG_W-1:0] CTRL_DEFAULT   = 16'h3100;
  localparam logic [REG_W-1:0] STAT_BASE      = 16'h7848;
  localparam logic [REG_W-1:0] STAT_LINK_BITS = 16'h0024;
  localparam logic [REG_W-1:0] ADV_DEFAULT    = 16'h01E1;
  localparam logic [REG_W-1:0] PARTNER_DOWN   = 16'h0080;
  localparam logic [REG_W-1:0] PARTNER_UP_ADD = 16'h0141;
  localparam logic [REG_W-1:0] FLOAT_VALUE    = 16'hFFFF;

  typedef struct packed {
    logic [REG_W-1:0] ctrl;
    logic [REG_W-1:0] stat;
    logic [REG_W-1:0] adv;
    logic [REG_W-1:0] partner;
  } phy_regs_t;
endpackage

// File: rtl/phy_mgmt_target.sv
module phy_mgmt_target #(
  parameter int ADDR_W = 8,
  parameter int IDX_W = 8,
  parameter logic [ADDR_W-1:0] PHY_ADDR = '0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [ADDR_W+IDX_W-1:0] wdata,
  output logic [ADDR_W+IDX_W-1:0] q,
  output logic [IDX_W-1:0]        idx,
  output logic                    addr_hit
);
  localparam int TGT_W = ADDR_W + IDX_W;

  logic [TGT_W-1:0] tgt_r;

  always_ff @(posedge clk) begin
    if (rst) tgt_r <= '0;
    else if (we) tgt_r <= wdata;
  end

  assign q        = tgt_r;
  assign idx      = tgt_r[IDX_W-1:0];
  assign addr_hit = (tgt_r[TGT_W-1:IDX_W] == PHY_ADDR);

  // R5: a load is visible on the next cycle
  assert_tgt_load_R5: assert property (@(posedge clk) disable iff (rst)
    we |=> (q == $past(wdata)));
endmodule

// File: rtl/phy_mgmt_core.sv
module phy_mgmt_core
  import phy_mgmt_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             link_up,
  input  logic             wr_en,
  input  logic             addr_hit,
  input  logic [IDX_W-1:0] idx,
  input  logic [REG_W-1:0] wr_data,
  output phy_regs_t        regs
);
  logic      link_q;
  logic      wr_hit;
  logic      soft_rst;
  phy_regs_t r;

  assign wr_hit   = wr_en && addr_hit;
  assign soft_rst = wr_hit && (idx == IDX_W'(IDX_CTRL)) && wr_data[CTRL_SOFT_RST_BIT];

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      r.ctrl    <= CTRL_DEFAULT;
      r.adv     <= ADV_DEFAULT;
      r.stat    <= link_up ? (STAT_BASE | STAT_LINK_BITS) : STAT_BASE;
      r.partner <= link_up ? (PARTNER_DOWN | PARTNER_UP_ADD) : PARTNER_DOWN;
      link_q    <= link_up;
    end else begin
      if (link_up != link_q) begin
        link_q <= link_up;
        if (link_up) begin
          r.stat    <= r.stat | STAT_LINK_BITS;
          r.partner <= r.partner | PARTNER_UP_ADD;
        end else begin
          r.stat    <= r.stat & ~STAT_LINK_BITS;
          r.partner <= PARTNER_DOWN;
        end
      end
      if (wr_hit && idx == IDX_W'(IDX_CTRL)) r.ctrl <= wr_data;
      if (wr_hit && idx == IDX_W'(IDX_ADV))  r.adv  <= wr_data;
    end
  end

  assign regs = r;

  // R2: link bits follow the input one edge later
  assert_link_up_bits_R2: assert property (@(posedge clk) disable iff (rst)
    link_up |=> (regs.stat[2] && regs.stat[5]));
  // R3: link down forces partner ability
  assert_link_down_partner_R3: assert property (@(posedge clk) disable iff (rst)
    !link_up |=> (regs.partner == PARTNER_DOWN && !regs.stat[2]));
  // R9: soft reset reloads defaults and drops the written value
  assert_soft_reset_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr_hit && idx == IDX_W'(IDX_CTRL) && wr_data[CTRL_SOFT_RST_BIT])
      |=> (regs.ctrl == CTRL_DEFAULT && regs.adv == ADV_DEFAULT));
  // R8: plain control write is stored
  assert_ctrl_store_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr_hit && idx == IDX_W'(IDX_CTRL) && !wr_data[CTRL_SOFT_RST_BIT])
      |=> (regs.ctrl == $past(wr_data)));
  // R10: foreign-address writes leave writable words alone
  assert_foreign_write_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr_hit) |=> ($stable(regs.ctrl) && $stable(regs.adv)));
endmodule

// File: rtl/phy_mgmt_rdmux.sv
module phy_mgmt_rdmux
  import phy_mgmt_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter logic [REG_W-1:0] ID_HI = 16'h0000,
  parameter logic [REG_W-1:0] ID_LO = 16'h0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic             addr_hit,
  input  logic [IDX_W-1:0] idx,
  input  phy_regs_t        regs,
  output logic [REG_W-1:0] rd_data,
  output logic             rd_valid
);
  logic [REG_W-1:0] sel;

  always_comb begin
    if (!addr_hit) sel = FLOAT_VALUE;
    else begin
      unique case (idx)
        IDX_W'(IDX_CTRL):    sel = regs.ctrl;
        IDX_W'(IDX_STAT):    sel = regs.stat;
        IDX_W'(IDX_ID_HI):   sel = ID_HI;
        IDX_W'(IDX_ID_LO):   sel = ID_LO;
        IDX_W'(IDX_ADV):     sel = regs.adv;
        IDX_W'(IDX_PARTNER): sel = regs.partner;
        default:             sel = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= sel;
    end
  end

  // R6: foreign address floats high
  assert_float_read_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !addr_hit) |=> (rd_data == FLOAT_VALUE));
  // R11: output holds without a read
  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> ($stable(rd_data) && !rd_valid));
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W = 8,
  parameter logic [ADDR_W-1:0] PHY_ADDR = 8'd1,
  parameter logic [15:0] ID_HI = 16'h0000,
  parameter logic [15:0] ID_LO = 16'h8201
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    link_up,
  input  logic                    tgt_we,
  input  logic [ADDR_W+IDX_W-1:0] tgt_wdata,
  output logic [ADDR_W+IDX_W-1:0] tgt_q,
  input  logic                    rd_en,
  output logic [15:0]             rd_data,
  output logic                    rd_valid,
  input  logic                    wr_en,
  input  logic [15:0]             wr_data
);
  logic [IDX_W-1:0] idx;
  logic             addr_hit;
  phy_regs_t        regs;

  phy_mgmt_target #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .PHY_ADDR(PHY_ADDR)) u_target (
    .clk(clk), .rst(rst), .we(tgt_we), .wdata(tgt_wdata),
    .q(tgt_q), .idx(idx), .addr_hit(addr_hit)
  );

  phy_mgmt_core #(.IDX_W(IDX_W)) u_core (
    .clk(clk), .rst(rst), .link_up(link_up), .wr_en(wr_en),
    .addr_hit(addr_hit), .idx(idx), .wr_data(wr_data), .regs(regs)
  );

  phy_mgmt_rdmux #(.IDX_W(IDX_W), .ID_HI(ID_HI), .ID_LO(ID_LO)) u_rdmux (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr_hit(addr_hit), .idx(idx),
    .regs(regs), .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: tb/tb_phy_mgmt_regs.sv
`timescale 1ns/1ps
module tb_phy_mgmt_regs;
  localparam logic [7:0]  PA  = 8'd5;
  localparam logic [15:0] IDH = 16'h1357;
  localparam logic [15:0] IDL = 16'h9BDF;

  logic clk = 0, rst = 1, link_up = 1;
  logic tgt_we = 0, rd_en = 0, wr_en = 0;
  logic [15:0] tgt_wdata = 0, wr_data = 0;
  logic [15:0] tgt_q, rd_data;
  logic rd_valid;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [15:0] ctrl_m, adv_m, partner_m;
  bit link_m;

  always #4 clk = ~clk;

  phy_mgmt_regs #(.PHY_ADDR(PA), .ID_HI(IDH), .ID_LO(IDL)) dut (
    .clk(clk), .rst(rst), .link_up(link_up), .tgt_we(tgt_we), .tgt_wdata(tgt_wdata),
    .tgt_q(tgt_q), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .wr_en(wr_en), .wr_data(wr_data)
  );

  function automatic logic [15:0] exp_rd(input logic [7:0] a, input logic [7:0] i);
    if (a != PA) return 16'hFFFF;
    case (i)
      8'd0: return ctrl_m;
      8'd1: return link_m ? 16'h786C : 16'h7848;
      8'd2: return IDH;
      8'd3: return IDL;
      8'd4: return adv_m;
      8'd5: return partner_m;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_tgt(input logic [7:0] a, input logic [7:0] i);
    tgt_we = 1; tgt_wdata = {a, i};
    @(negedge clk);
    tgt_we = 0;
  endtask

  task automatic do_rd(output logic [15:0] v);
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    v = rd_data;
    chk("R11 valid", {15'd0, rd_valid}, 16'd1);
  endtask

  task automatic do_wr(input logic [15:0] v);
    wr_en = 1; wr_data = v;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] i);
    logic [15:0] v;
    set_tgt(a, i);
    do_rd(v);
    chk(req, v, exp_rd(a, i));
  endtask

  task automatic set_link(input bit l);
    link_up = l;
    @(negedge clk);
    if (l && !link_m) partner_m = partner_m | 16'h0141;
    if (!l && link_m) partner_m = 16'h0080;
    link_m = l;
  endtask

  task automatic model_reset();
    ctrl_m = 16'h3100; adv_m = 16'h01E1;
    partner_m = link_m ? 16'h01C1 : 16'h0080;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, prev;
    link_m = 1;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 target", tgt_q, 16'h0000);
    chk("R1 rd_valid", {15'd0, rd_valid}, 16'd0);
    // R7 R2 R3 sweep every index at the matching address
    for (int i = 0; i < 256; i++) rd_chk("R7 index map", PA, 8'(i));
    // R6 sweep every address
    for (int a = 0; a < 256; a++) rd_chk("R6 address", 8'(a), 8'd1);

    // R4 link falls with a read on the same edge
    set_tgt(PA, 8'd1);
    link_up = 0; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    chk("R4 old status", rd_data, 16'h786C);
    link_m = 0; partner_m = 16'h0080;
    rd_chk("R2 down status", PA, 8'd1);
    rd_chk("R3 down partner", PA, 8'd5);
    set_link(1);
    rd_chk("R3 up partner", PA, 8'd5);
    rd_chk("R2 up status", PA, 8'd1);

    // R8 R10 write sweep on every index
    for (int i = 0; i < 256; i++) begin
      set_tgt(PA, 8'(i));
      do_wr(16'h0400 | 16'(i));
      if (i == 0) ctrl_m = 16'h0400;
      if (i == 4) adv_m = 16'h0404;
      rd_chk("R10 written index", PA, 8'(i));
      rd_chk("R8 ctrl", PA, 8'd0);
      rd_chk("R8 adv", PA, 8'd4);
    end
    // R10 foreign-address writes
    for (int a = 0; a < 256; a++) begin
      if (8'(a) == PA) continue;
      set_tgt(8'(a), 8'd0);
      do_wr(16'h1111);
      set_tgt(8'(a), 8'd4);
      do_wr(16'h2222);
    end
    rd_chk("R10 ctrl kept", PA, 8'd0);
    rd_chk("R10 adv kept", PA, 8'd4);

    // R9 soft reset with link up and down
    set_tgt(PA, 8'd0);
    do_wr(16'h8ABC);
    model_reset();
    for (int i = 0; i < 6; i++) rd_chk("R9 soft reset up", PA, 8'(i));
    set_link(0);
    set_tgt(PA, 8'd4); do_wr(16'h0001); adv_m = 16'h0001;
    set_tgt(PA, 8'd0); do_wr(16'hFFFF);
    model_reset();
    for (int i = 0; i < 6; i++) rd_chk("R9 soft reset down", PA, 8'(i));

    // R5 target rewritten on the read edge
    set_tgt(PA, 8'd2);
    tgt_we = 1; tgt_wdata = {PA, 8'd3}; rd_en = 1;
    @(negedge clk);
    tgt_we = 0; rd_en = 0;
    chk("R5 old target", rd_data, IDH);
    chk("R5 new target", tgt_q, {PA, 8'd3});

    // R11 hold without read
    prev = rd_data;
    set_tgt(PA, 8'd0);
    repeat (3) @(negedge clk);
    chk("R11 hold", rd_data, prev);
    chk("R11 no valid", {15'd0, rd_valid}, 16'd0);
    do_rd(v);
    chk("R11 data", v, exp_rd(PA, 8'd0));

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule